// File: doc/BRIEF.md
# Multiplexed 24-Hour Digital Clock

This block keeps the time of day from a 1 kHz system clock and drives an eight-position, time-shared seven-segment display. A prescaler divides the system clock by 1000 to form a one-cycle seconds tick. Three cascaded BCD counters use that tick as an enable: seconds, then minutes, then hours. Every counter shares the single system clock, so no derived clock is ever used as a clock.

The display side steps through eight positions under an external scan enable, and outputs the position index as a 3-bit select code for an off-block digit decoder. Six positions show the two digits of each time field and two show a dash that separates the fields. The seven segment lines and the select code leave the block from registers, as a matched pair. The packed BCD time is also brought out so that the counting can be checked directly.

Reset is active high and synchronous. It clears the prescaler, all three counters, the scan position and both display registers.

Top module: `mux_clock24`

## Requirements
- R1: While `rst` is high at a clock edge, the time reads 00:00:00, `sel_o` reads 0 and `seg_o` reads 0111111. The prescaler also restarts, so the first seconds increment after reset comes exactly 1000 edges after `rst` is released.
- R2: The seconds value increments once every `DIV_CYCLES` (1000) clock edges. It holds its value between those edges.
- R3: Seconds count from 00 to 59. On the step out of 59 they return to 00, and minutes advance by one on that same edge and on no other edge.
- R4: Minutes count from 00 to 59. They step only when seconds wrap. When minutes and seconds both wrap on the same edge, hours advance by one.
- R5: Hours count from 00 to 23. The step after 23:59:59 gives 00:00:00.
- R6: `time_o` carries hours in bits 23:16, minutes in bits 15:8 and seconds in bits 7:0. Each field is two BCD digits, with the tens digit in the upper nibble. No units digit exceeds 9, no minutes or seconds tens digit exceeds 5, and hours never exceed 23.
- R7: The scan position advances by one on every edge where `scan_en` is high, and wraps from 7 to 0. It holds while `scan_en` is low.
- R8: Display positions map as follows: 0 shows the seconds tens digit and 1 the seconds units digit. 3 and 4 show the hours tens and units digits. 6 and 7 show the minutes tens and units digits. Positions 2 and 5 show a dash.
- R9: `seg_o` is active high, with bit 6 as segment g and bit 0 as segment a. The digit patterns are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111. A dash is 1000000.
- R10: `sel_o` and `seg_o` are registered together. After each edge they show the scan position and time as they stood before that edge, so a scan step appears on `sel_o` one edge after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 1 kHz |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Advances the display position on each edge where it is high |
| seg_o | output | 7 | Segment lines g..a, active high, registered |
| sel_o | output | 3 | Displayed position index, registered |
| time_o | output | 24 | Packed BCD time: hours, minutes, seconds |

## Verification
The counters are exercised in two ways. At the nominal division, the bench confirms tick spacing and that reset restarts the prescaler. At a division of one, the whole day passes within the run, so each carry boundary (59 s, 59:59, 23:59:59) and every intermediate value can be compared against a reference model. The display is driven in three patterns: single isolated scan steps with a known time, which pin down the position mapping and the one-edge output lag; a continuous enable burst, which shows wrapping; and an enable that is high two cycles in three during the full-speed day, which pairs every glyph with every position while the time keeps changing.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

  localparam int SEG_W    = 7;
  localparam int SCAN_POS = 8;
  localparam int SCAN_W   = $clog2(SCAN_POS);
  localparam int FIELD_W  = 8;
  localparam int TIME_W   = 3 * FIELD_W;

  // Nibble code that selects the separator glyph
  localparam logic [3:0] NIB_DASH = 4'd10;

  typedef logic [FIELD_W-1:0] bcd_pair_t;

  typedef struct packed {
    bcd_pair_t hr;
    bcd_pair_t mn;
    bcd_pair_t sc;
  } clk_time_t;

  // Segment order g f e d c b a, active high
  function automatic logic [SEG_W-1:0] glyph(input logic [3:0] nib);
    logic [SEG_W-1:0] pat;
    case (nib)
      4'd0:    pat = 7'b0111111;
      4'd1:    pat = 7'b0000110;
      4'd2:    pat = 7'b1011011;
      4'd3:    pat = 7'b1001111;
      4'd4:    pat = 7'b1100110;
      4'd5:    pat = 7'b1101101;
      4'd6:    pat = 7'b1111101;
      4'd7:    pat = 7'b0000111;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1101111;
      NIB_DASH: pat = 7'b1000000;
      default: pat = 7'b0000000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/clkm_prescaler.sv
module clkm_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_inputs;
      assign unused_inputs = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/clkm_bcd_counter.sv
module clkm_bcd_counter #(
  parameter int MODULUS = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  output logic [7:0] bcd_o,
  output logic       at_last
);

  localparam logic [3:0] LAST_T = 4'((MODULUS - 1) / 10);
  localparam logic [3:0] LAST_U = 4'((MODULUS - 1) % 10);

  logic [3:0] tens_q;
  logic [3:0] units_q;

  assign at_last = (tens_q == LAST_T) && (units_q == LAST_U);

  always_ff @(posedge clk) begin
    if (rst) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (inc) begin
      if (at_last) begin
        tens_q  <= '0;
        units_q <= '0;
      end else if (units_q == 4'd9) begin
        units_q <= '0;
        tens_q  <= tens_q + 4'd1;
      end else begin
        units_q <= units_q + 4'd1;
      end
    end
  end

  assign bcd_o = {tens_q, units_q};

endmodule

// File: rtl/clkm_scan_driver.sv
module clkm_scan_driver
  import clkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  clk_time_t         now,
  output logic [SCAN_W-1:0] pos_o,
  output logic [SCAN_W-1:0] sel_o,
  output logic [SEG_W-1:0]  seg_o
);

  localparam logic [SCAN_W-1:0] POS_LAST = SCAN_W'(SCAN_POS - 1);

  logic [SCAN_W-1:0] pos_q;
  logic [3:0]        nib;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (step) begin
      pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + SCAN_W'(1);
    end
  end

  // Position to digit source; positions 2 and 5 are separators
  always_comb begin
    case (pos_q)
      3'd0:    nib = now.sc[7:4];
      3'd1:    nib = now.sc[3:0];
      3'd3:    nib = now.hr[7:4];
      3'd4:    nib = now.hr[3:0];
      3'd6:    nib = now.mn[7:4];
      3'd7:    nib = now.mn[3:0];
      default: nib = NIB_DASH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= '0;
      seg_o <= glyph(4'd0);
    end else begin
      sel_o <= pos_q;
      seg_o <= glyph(nib);
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/mux_clock24.sv
module mux_clock24
  import clkm_pkg::*;
#(
  parameter int DIV_CYCLES = 1000,
  parameter int SEC_MOD    = 60,
  parameter int MIN_MOD    = 60,
  parameter int HR_MOD     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_en,
  output logic [SEG_W-1:0]  seg_o,
  output logic [SCAN_W-1:0] sel_o,
  output logic [TIME_W-1:0] time_o
);

  logic              sec_tick;
  logic              sec_last;
  logic              min_last;
  logic              hr_last_unused;
  logic              min_inc;
  logic              hr_inc;
  bcd_pair_t         sec_bcd;
  bcd_pair_t         min_bcd;
  bcd_pair_t         hr_bcd;
  clk_time_t         now;
  logic [SCAN_W-1:0] scan_pos;

  clkm_prescaler #(.DIV(DIV_CYCLES)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (sec_tick)
  );

  assign min_inc = sec_tick & sec_last;
  assign hr_inc  = min_inc & min_last;

  clkm_bcd_counter #(.MODULUS(SEC_MOD)) u_sec (
    .clk     (clk),
    .rst     (rst),
    .inc     (sec_tick),
    .bcd_o   (sec_bcd),
    .at_last (sec_last)
  );

  clkm_bcd_counter #(.MODULUS(MIN_MOD)) u_min (
    .clk     (clk),
    .rst     (rst),
    .inc     (min_inc),
    .bcd_o   (min_bcd),
    .at_last (min_last)
  );

  clkm_bcd_counter #(.MODULUS(HR_MOD)) u_hr (
    .clk     (clk),
    .rst     (rst),
    .inc     (hr_inc),
    .bcd_o   (hr_bcd),
    .at_last (hr_last_unused)
  );

  assign now    = '{hr: hr_bcd, mn: min_bcd, sc: sec_bcd};
  assign time_o = now;

  clkm_scan_driver u_scan (
    .clk   (clk),
    .rst   (rst),
    .step  (scan_en),
    .now   (now),
    .pos_o (scan_pos),
    .sel_o (sel_o),
    .seg_o (seg_o)
  );

endmodule

// File: rtl/mux_clock24_chk.sv
module mux_clock24_chk
  import clkm_pkg::*;
#(
  parameter int DIV_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_en,
  input logic              sec_tick,
  input logic [SCAN_W-1:0] scan_pos,
  input logic [SCAN_W-1:0] sel_o,
  input logic [SEG_W-1:0]  seg_o,
  input logic [TIME_W-1:0] time_o
);

  int gap_q;

  always_ff @(posedge clk) begin
    if (rst || sec_tick) begin
      gap_q <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (time_o == '0 && sel_o == '0 && scan_pos == '0));

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> (gap_q == DIV_CYCLES - 1));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> (time_o == $past(time_o)));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && time_o[7:0] == 8'h59) |=>
      (time_o[7:0] == 8'h00 && time_o[15:8] != $past(time_o[15:8])));

  assert_min_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && time_o[15:0] == 16'h5959) |=>
      (time_o[15:0] == 16'h0000 && time_o[23:16] != $past(time_o[23:16])));

  assert_day_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && time_o == 24'h235959) |=> (time_o == 24'h000000));

  assert_bcd_range_R6: assert property (@(posedge clk) disable iff (rst)
    (time_o[3:0] <= 4'd9 && time_o[7:4] <= 4'd5 &&
     time_o[11:8] <= 4'd9 && time_o[15:12] <= 4'd5 &&
     time_o[23:20] <= 4'd2 && time_o[19:16] <= 4'd9 &&
     (time_o[23:20] != 4'd2 || time_o[19:16] <= 4'd3)));

  assert_scan_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> (scan_pos == $past(scan_pos)));

  assert_scan_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (scan_en && scan_pos == SCAN_W'(SCAN_POS - 1)) |=> (scan_pos == '0));

  assert_dash_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_o == 3'd2 || sel_o == 3'd5) |-> (seg_o == 7'b1000000));

endmodule

bind mux_clock24 mux_clock24_chk #(.DIV_CYCLES(DIV_CYCLES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .scan_en  (scan_en),
  .sec_tick (sec_tick),
  .scan_pos (scan_pos),
  .sel_o    (sel_o),
  .seg_o    (seg_o),
  .time_o   (time_o)
);

// File: tb/mux_clock24_tb_top.sv
module clkm_ref_model #(
  parameter int DIV = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [23:0] t_o,
  output logic [6:0]  seg_o,
  output logic [2:0]  sel_o
);

  int pc;
  int secs;
  int idx;

  function automatic logic [6:0] shape(input int d);
    case (d)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      9: return 7'b1101111;
      10: return 7'b1000000;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int digit_at(input int p, input int s);
    int h, m, c;
    h = s / 3600;
    m = (s / 60) % 60;
    c = s % 60;
    case (p)
      0: return c / 10;
      1: return c % 10;
      3: return h / 10;
      4: return h % 10;
      6: return m / 10;
      7: return m % 10;
      default: return 10;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pc    <= 0;
      secs  <= 0;
      idx   <= 0;
      sel_o <= 3'd0;
      seg_o <= shape(0);
    end else begin
      sel_o <= 3'(idx);
      seg_o <= shape(digit_at(idx, secs));
      if (step) idx <= (idx + 1) % 8;
      if (pc == DIV - 1) begin
        pc   <= 0;
        secs <= (secs + 1) % 86400;
      end else begin
        pc <= pc + 1;
      end
    end
  end

  always_comb begin
    int h, m, c;
    h = secs / 3600;
    m = (secs / 60) % 60;
    c = secs % 60;
    t_o = {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(c / 10), 4'(c % 10)};
  end

endmodule

module mux_clock24_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_en = 1'b0;
  logic        scan_en_f = 1'b0;

  logic [6:0]  seg, seg_f, rseg, rseg_f;
  logic [2:0]  sel, sel_f, rsel, rsel_f;
  logic [23:0] tim, tim_f, rtim, rtim_f;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mux_clock24 dut_i (
    .clk(clk), .rst(rst), .scan_en(scan_en),
    .seg_o(seg), .sel_o(sel), .time_o(tim)
  );

  mux_clock24 #(.DIV_CYCLES(1)) dut_fast_i (
    .clk(clk), .rst(rst), .scan_en(scan_en_f),
    .seg_o(seg_f), .sel_o(sel_f), .time_o(tim_f)
  );

  clkm_ref_model #(.DIV(1000)) ref_i (
    .clk(clk), .rst(rst), .step(scan_en), .t_o(rtim), .seg_o(rseg), .sel_o(rsel)
  );

  clkm_ref_model #(.DIV(1)) ref_fast_i (
    .clk(clk), .rst(rst), .step(scan_en_f), .t_o(rtim_f), .seg_o(rseg_f), .sel_o(rsel_f)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    scan_en = 1'b0;
    scan_en_f = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state and mid-run reset restarting the prescaler
  task automatic t_reset_state();
    apply_reset();
    check("R1", "time after reset", 32'(tim), 32'h000000);
    check("R1", "sel after reset", 32'(sel), 32'd0);
    check("R1", "seg after reset", 32'(seg), 32'b0111111);
    check("R1", "fast time after reset", 32'(tim_f), 32'h000000);
    wait_n(1500);
    check("R2", "one second elapsed", 32'(tim), 32'h000001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "time after mid-run reset", 32'(tim), 32'h000000);
    wait_n(999);
    check("R1", "prescaler restarted, no tick yet", 32'(tim), 32'h000000);
    wait_n(1);
    check("R1", "first tick 1000 edges after reset", 32'(tim), 32'h000001);
  endtask

  // R2: tick period
  task automatic t_prescaler();
    apply_reset();
    wait_n(999);
    check("R2", "before first tick", 32'(tim), 32'h000000);
    wait_n(1);
    check("R2", "after first tick", 32'(tim), 32'h000001);
    wait_n(999);
    check("R2", "held between ticks", 32'(tim), 32'h000001);
    wait_n(1);
    check("R2", "after second tick", 32'(tim), 32'h000002);
  endtask

  // R3 R4 R5 R6 R8 R9: a full day at one second per edge
  task automatic t_full_day();
    int bad_t, bad_d;
    bad_t = 0;
    bad_d = 0;
    apply_reset();
    for (int n = 1; n <= 86401; n++) begin
      scan_en_f = (n % 3 != 0);
      @(negedge clk);
      if (tim_f !== rtim_f) bad_t++;
      if (seg_f !== rseg_f || sel_f !== rsel_f) bad_d++;
      case (n)
        59:    check("R3", "seconds at 59", 32'(tim_f), 32'h000059);
        60:    check("R3", "seconds wrap into minute", 32'(tim_f), 32'h000100);
        3599:  check("R4", "59:59", 32'(tim_f), 32'h005959);
        3600:  check("R4", "minutes wrap into hour", 32'(tim_f), 32'h010000);
        36000: check("R6", "hours tens digit", 32'(tim_f), 32'h100000);
        45296: check("R6", "packed 12:34:56", 32'(tim_f), 32'h123456);
        86399: check("R5", "23:59:59", 32'(tim_f), 32'h235959);
        86400: check("R5", "day rollover", 32'(tim_f), 32'h000000);
        default: ;
      endcase
    end
    scan_en_f = 1'b0;
    check("R6", "time matches model all day", 32'(bad_t), 32'd0);
    check("R9", "display matches model all day (R8 mapping)", 32'(bad_d), 32'd0);
  endtask

  // R7 R8 R9 R10: isolated scan steps on a known time of 00:00:07
  task automatic t_scan_steps();
    logic [6:0] exp_seg [8];
    logic [2:0] prev;
    exp_seg[0] = 7'b0111111;
    exp_seg[1] = 7'b0000111;
    exp_seg[2] = 7'b1000000;
    exp_seg[3] = 7'b0111111;
    exp_seg[4] = 7'b0111111;
    exp_seg[5] = 7'b1000000;
    exp_seg[6] = 7'b0111111;
    exp_seg[7] = 7'b0111111;
    apply_reset();
    wait_n(7000);
    check("R2", "seven seconds", 32'(tim), 32'h000007);
    check("R8", "position 0 idle sel", 32'(sel), 32'd0);
    check("R8", "position 0 glyph", 32'(seg), 32'(exp_seg[0]));
    for (int k = 1; k <= 8; k++) begin
      prev = sel;
      scan_en = 1'b1;
      @(negedge clk);
      scan_en = 1'b0;
      check("R10", "sel lags step by one edge", 32'(sel), 32'(prev));
      @(negedge clk);
      check("R7", "sel after step", 32'(sel), 32'(k % 8));
      check("R8", "glyph at position (R9 pattern)", 32'(seg), 32'(exp_seg[k % 8]));
    end
    wait_n(5);
    check("R7", "sel holds with enable low", 32'(sel), 32'd0);
  endtask

  // R7: continuous enable burst wraps
  task automatic t_scan_burst();
    logic [2:0] s0;
    s0 = sel;
    scan_en = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      check("R7", "burst position", 32'(sel), 32'((s0 + i - 1) % 8));
    end
    scan_en = 1'b0;
    wait_n(2);
    check("R7", "burst end position", 32'(sel), 32'((s0 + 10) % 8));
    check("R8", "model agreement after burst", 32'(seg), 32'(rseg));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prescaler();
    t_full_day();
    t_scan_steps();
    t_scan_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule